// File: doc/BRIEF.md
# Multi-layer overlay compositor

This block merges up to four layer pixel streams (one graphics layer and three video layers) into a single RGB pixel per pixel strobe for a display output. All layers arrive already aligned to a shared strobe, each carrying 8-bit-per-channel ARGB. The block stacks the enabled layers in a programmable z-order and composites them from bottom to top over a programmable background color. Each layer is weighted by its embedded pixel alpha and its per-layer global alpha. The stack can also be filtered by a transparency color key that acts on either the source or the destination.

Configuration comes in as plain register-style inputs: layer enables, z-order ranks, global alphas, premultiplied flags, key mode, key color and background color. These are sampled in the same cycle as the pixels they apply to. The result leaves through a valid/data pair with a fixed latency of two cycles and goes to a downstream formatter.

Top module: `overlay_compositor`

## Requirements
- R1: Each of the four layers has its own enable bit (`layer_en_i[i]`). A disabled layer has no effect on the output, whatever its pixel or configuration, and any number of layers from one to four may be enabled.
- R2: Layer i occupies `pix_i[32*i +: 32]` as {A[31:24], R[23:16], G[15:8], B[7:0]}. Layer 0 is the graphics layer and layers 1 to 3 are video. `rgb_o` is {R[23:16], G[15:8], B[7:0]}.
- R3: Each layer has a 2-bit rank at `zrank_i[2*i +: 2]`. A lower rank lies beneath a higher rank, and any assignment of ranks is accepted.
- R4: When two layers hold equal ranks, the layer with the lower index lies beneath the other.
- R5: A non-premultiplied layer (`premult_i[i]=0`) blends each channel as out = (s*a + d*(255-a) + 127)/255. Here a = (pixel_alpha*global_alpha)/255 (integer division), global alpha is `galpha_i[8*i +: 8]`, and d is the composite beneath the layer.
- R6: A premultiplied layer (`premult_i[i]=1`) blends each channel as out = min(255, (s*global_alpha + d*(255-a) + 127)/255), with a as in R5. Its color is not multiplied by its pixel alpha again.
- R7: With `key_mode_i=2'b01` (source key), any enabled layer pixel whose RGB equals `key_color_i` is skipped.
- R8: With `key_mode_i=2'b10` (destination key), an enabled layer is drawn only where the composite beneath it (starting from the background) equals `key_color_i`. Elsewhere it is skipped.
- R9: With `key_mode_i` equal to 2'b00 or 2'b11, no keying takes place.
- R10: When no layer is enabled, or every layer is skipped, the output equals `bg_color_i`.
- R11: `valid_o` repeats `valid_i` exactly two cycles later. The `rgb_o` presented with it is computed from the pixels and configuration sampled alongside that `valid_i`.
- R12: While `rst_ni` is low, `valid_o` is 0 and `rgb_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Pixel strobe for all layers |
| pix_i | input | 128 | Four ARGB pixels, layer i at bits 32*i+31..32*i |
| layer_en_i | input | 4 | Per-layer enable |
| zrank_i | input | 8 | Per-layer z-order rank, 2 bits each |
| galpha_i | input | 32 | Per-layer global alpha, 8 bits each |
| premult_i | input | 4 | Per-layer premultiplied-color flag |
| key_mode_i | input | 2 | 00/11 off, 01 source key, 10 destination key |
| key_color_i | input | 24 | Transparency key RGB |
| bg_color_i | input | 24 | Background RGB |
| valid_o | output | 1 | Output pixel strobe |
| rgb_o | output | 24 | Composited RGB pixel |

## Verification
The bench aims at rank ties: a sorter that breaks them the wrong way puts the higher-index layer underneath, and an opaque tie then shows the wrong color. It also covers the two key modes separately. A source-key fault lets key-colored pixels paint over the stack, and a destination-key fault draws a layer over a non-key composite or tests the key against the wrong operand. Premultiplied layers and fractional alphas expose rounding or double-multiplication errors, which shift channels by one count or darken them. The all-disabled, all-skipped and valid-gap cases catch a missing background fallback and a latency that is not exactly two cycles.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  typedef logic [23:0] rgb_t;

  localparam logic [1:0] KEY_SRC = 2'b01;
  localparam logic [1:0] KEY_DST = 2'b10;
endpackage

// File: rtl/ovl_zsort.sv
module ovl_zsort #(
  parameter int N_LAYERS = 4,
  localparam int IW = $clog2(N_LAYERS)
) (
  input  logic [N_LAYERS*IW-1:0] rank_i,
  output logic [N_LAYERS*IW-1:0] slot_o
);
  logic [IW-1:0] pos [N_LAYERS];

  // position = layers strictly beneath (lower rank, or equal rank with lower index)
  for (genvar i = 0; i < N_LAYERS; i++) begin : g_pos
    always_comb begin
      pos[i] = '0;
      for (int j = 0; j < N_LAYERS; j++) begin
        if (j != i) begin
          if ((rank_i[j*IW +: IW] < rank_i[i*IW +: IW]) ||
              ((rank_i[j*IW +: IW] == rank_i[i*IW +: IW]) && (j < i)))
            pos[i] = pos[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    slot_o = '0;
    for (int p = 0; p < N_LAYERS; p++)
      for (int i = 0; i < N_LAYERS; i++)
        if (pos[i] == IW'(p)) slot_o[p*IW +: IW] = IW'(i);
  end
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
  import ovl_pkg::*;
(
  input  rgb_t       dst_i,
  input  argb_t      pix_i,
  input  logic [7:0] ga_i,
  input  logic       en_i,
  input  logic       pm_i,
  input  logic [1:0] mode_i,
  input  rgb_t       key_i,
  output rgb_t       out_o
);
  logic [15:0] a_prod;
  logic [7:0]  a_eff;
  logic [7:0]  s_w;
  logic        use_l;
  rgb_t        src;
  rgb_t        mix;

  function automatic logic [7:0] chan(input logic [7:0] s, input logic [7:0] d,
                                      input logic [7:0] ws, input logic [7:0] a);
    logic [17:0] num;
    logic [17:0] q;
    num = 18'(s) * 18'(ws) + 18'(d) * 18'(8'd255 - a) + 18'd127;
    q   = num / 18'd255;
    return (q > 18'd255) ? 8'd255 : q[7:0];
  endfunction

  assign src    = {pix_i.r, pix_i.g, pix_i.b};
  assign a_prod = 16'(pix_i.a) * 16'(ga_i);
  assign a_eff  = 8'(a_prod / 16'd255);
  assign s_w    = pm_i ? ga_i : a_eff;
  assign use_l  = en_i && !((mode_i == KEY_SRC) && (src == key_i))
                       && !((mode_i == KEY_DST) && (dst_i != key_i));

  assign mix = {chan(pix_i.r, dst_i[23:16], s_w, a_eff),
                chan(pix_i.g, dst_i[15:8],  s_w, a_eff),
                chan(pix_i.b, dst_i[7:0],   s_w, a_eff)};

  assign out_o = use_l ? mix : dst_i;

  always_comb begin
    if (use_l && !pm_i && a_eff == 8'd255)
      assert_opaque_R5: assert (out_o == src);
    if (!en_i)
      assert_disabled_R1: assert (out_o == dst_i);
  end
endmodule

// File: rtl/overlay_compositor.sv
module overlay_compositor
  import ovl_pkg::*;
#(
  parameter int N_LAYERS = 4,
  localparam int IW = $clog2(N_LAYERS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [N_LAYERS*32-1:0] pix_i,
  input  logic [N_LAYERS-1:0]    layer_en_i,
  input  logic [N_LAYERS*IW-1:0] zrank_i,
  input  logic [N_LAYERS*8-1:0]  galpha_i,
  input  logic [N_LAYERS-1:0]    premult_i,
  input  logic [1:0]             key_mode_i,
  input  logic [23:0]            key_color_i,
  input  logic [23:0]            bg_color_i,
  output logic                  valid_o,
  output logic [23:0]           rgb_o
);
  logic [N_LAYERS*IW-1:0] slot_d;
  logic [N_LAYERS*IW-1:0] slot_q;
  logic                   v1_q;
  logic [N_LAYERS*32-1:0] pix_q;
  logic [N_LAYERS-1:0]    en_q;
  logic [N_LAYERS*8-1:0]  ga_q;
  logic [N_LAYERS-1:0]    pm_q;
  logic [1:0]             mode_q;
  rgb_t                   key_q;
  rgb_t                   bg_q;
  rgb_t                   chain [N_LAYERS+1];

  ovl_zsort #(.N_LAYERS(N_LAYERS)) u_zsort (
    .rank_i(zrank_i),
    .slot_o(slot_d)
  );

  // stage 1: capture pixels, configuration and stacking order
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      pix_q  <= '0;
      en_q   <= '0;
      ga_q   <= '0;
      pm_q   <= '0;
      mode_q <= '0;
      key_q  <= '0;
      bg_q   <= '0;
      for (int p = 0; p < N_LAYERS; p++) slot_q[p*IW +: IW] <= IW'(p);
    end else begin
      v1_q   <= valid_i;
      pix_q  <= pix_i;
      en_q   <= layer_en_i;
      ga_q   <= galpha_i;
      pm_q   <= premult_i;
      mode_q <= key_mode_i;
      key_q  <= key_color_i;
      bg_q   <= bg_color_i;
      slot_q <= slot_d;
    end
  end

  // stage 2: bottom-to-top blend chain
  assign chain[0] = bg_q;
  for (genvar p = 0; p < N_LAYERS; p++) begin : g_stack
    logic [IW-1:0] idx;
    assign idx = slot_q[p*IW +: IW];
    ovl_blend u_blend (
      .dst_i (chain[p]),
      .pix_i (argb_t'(pix_q[idx*32 +: 32])),
      .ga_i  (ga_q[idx*8 +: 8]),
      .en_i  (en_q[idx]),
      .pm_i  (pm_q[idx]),
      .mode_i(mode_q),
      .key_i (key_q),
      .out_o (chain[p+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rgb_o   <= '0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) rgb_o <= chain[N_LAYERS];
    end
  end

  // checks
  logic [N_LAYERS-1:0] covered;
  logic [1:0]          since_rst;

  always_comb begin
    covered = '0;
    for (int p = 0; p < N_LAYERS; p++) covered[slot_q[p*IW +: IW]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_perm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(covered) == N_LAYERS);

  assert_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  assert_bg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && en_q == '0) |=> (rgb_o == $past(bg_q)));

  assert_reset_R12: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && rgb_o == '0));
endmodule

// File: tb/overlay_compositor_tb_top.sv
module overlay_compositor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] pix [4];
  logic [3:0]  en = '0;
  logic [1:0]  rank [4];
  logic [7:0]  ga [4];
  logic [3:0]  pm = '0;
  logic [1:0]  mode = '0;
  logic [23:0] key = '0;
  logic [23:0] bg = '0;
  logic        valid_o;
  logic [23:0] rgb_o;
  logic [127:0] pix_flat;
  logic [7:0]   rank_flat;
  logic [31:0]  ga_flat;

  int checks = 0;
  int errors = 0;
  bit q_v [2];
  logic [23:0] q_rgb [2];
  string q_tag [2];

  initial for (int i = 0; i < 4; i++) begin
    pix[i] = '0; rank[i] = 2'(i); ga[i] = 8'd255;
  end

  always_comb for (int i = 0; i < 4; i++) begin
    pix_flat[32*i +: 32] = pix[i];
    rank_flat[2*i +: 2]  = rank[i];
    ga_flat[8*i +: 8]    = ga[i];
  end

  always #10 clk = ~clk;

  overlay_compositor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pix_i(pix_flat),
    .layer_en_i(en), .zrank_i(rank_flat), .galpha_i(ga_flat), .premult_i(pm),
    .key_mode_i(mode), .key_color_i(key), .bg_color_i(bg),
    .valid_o(valid_o), .rgb_o(rgb_o)
  );

  function automatic logic [7:0] ref_ch(logic [7:0] s, logic [7:0] d, logic [7:0] a,
                                        logic [7:0] g, bit p);
    int num;
    num = (p ? int'(s) * int'(g) : int'(s) * int'(a)) + int'(d) * (255 - int'(a)) + 127;
    num = num / 255;
    return (num > 255) ? 8'd255 : 8'(num);
  endfunction

  function automatic logic [23:0] ref_model();
    logic [23:0] d;
    d = bg;
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 4; i++)
        if (rank[i] == 2'(r) && en[i]) begin
          logic [23:0] s;
          logic [7:0] a;
          s = pix[i][23:0];
          a = 8'((int'(pix[i][31:24]) * int'(ga[i])) / 255);
          if (mode == 2'b01 && s == key) continue;
          if (mode == 2'b10 && d != key) continue;
          d = {ref_ch(s[23:16], d[23:16], a, ga[i], pm[i]),
               ref_ch(s[15:8],  d[15:8],  a, ga[i], pm[i]),
               ref_ch(s[7:0],   d[7:0],   a, ga[i], pm[i])};
        end
    return d;
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, string tag);
    valid = v;
    q_v[1] = q_v[0]; q_rgb[1] = q_rgb[0]; q_tag[1] = q_tag[0];
    q_v[0] = v; q_rgb[0] = ref_model(); q_tag[0] = tag;
    @(negedge clk);
    check({q_tag[1], " R11 valid"}, 24'(valid_o), 24'(q_v[1]));
    if (q_v[1]) check(q_tag[1], rgb_o, q_rgb[1]);
  endtask

  task automatic opaque_all();
    for (int i = 0; i < 4; i++) begin
      ga[i] = 8'd255; pix[i][31:24] = 8'hff; rank[i] = 2'(i);
    end
    pm = '0; mode = 2'b00;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    q_v[0] = 0; q_v[1] = 0; q_rgb[0] = '0; q_rgb[1] = '0; q_tag[0] = ""; q_tag[1] = "";
    #5;
    check("R12 reset valid", 24'(valid_o), 24'd0);
    check("R12 reset rgb", rgb_o, 24'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    pix[0] = 32'hff102030; pix[1] = 32'hff405060; pix[2] = 32'hff708090; pix[3] = 32'hffa0b0c0;
    bg = 24'h0a0b0c;
    en = 4'b0000; step(1, "R10 no layer");
    en = 4'b0001; opaque_all(); step(1, "R1 R2 single layer");
    en = 4'b0100; step(1, "R1 video layer only");
    en = 4'b1111; rank[0] = 2'd3; rank[1] = 2'd2; rank[2] = 2'd1; rank[3] = 2'd0;
    step(1, "R3 reversed order");
    rank[0] = 2'd1; rank[1] = 2'd3; rank[2] = 2'd0; rank[3] = 2'd2; step(1, "R3 permutation");
    rank[0] = 2'd2; rank[1] = 2'd2; rank[2] = 2'd0; rank[3] = 2'd0; step(1, "R4 tie");
    step(0, "R11 gap");
    opaque_all(); en = 4'b0011; pix[1][31:24] = 8'h80; ga[1] = 8'hc0; step(1, "R5 fractional alpha");
    pm = 4'b0010; pix[1] = 32'h80404040; step(1, "R6 premultiplied");
    pix[1] = 32'h40ffffff; ga[1] = 8'hff; step(1, "R6 premult clamp");
    opaque_all(); en = 4'b0011; mode = 2'b01; key = pix[1][23:0]; step(1, "R7 source key hit");
    key = 24'h123456; step(1, "R7 source key miss");
    en = 4'b0001; key = pix[0][23:0]; bg = 24'h555555; step(1, "R10 all keyed");
    mode = 2'b10; en = 4'b0011; key = bg; step(1, "R8 destination key");
    key = pix[0][23:0]; step(1, "R8 destination key on layer");
    mode = 2'b11; step(1, "R9 mode 11 no key");
    mode = 2'b00; key = pix[1][23:0]; step(1, "R9 mode 00 no key");

    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 4; i++) begin
        pix[i] = $urandom;
        rank[i] = 2'($urandom);
        ga[i] = ($urandom_range(0, 3) == 0) ? 8'hff : 8'($urandom);
      end
      en = 4'($urandom); pm = 4'($urandom); mode = 2'($urandom);
      bg = 24'($urandom);
      key = ($urandom_range(0, 1) == 1) ? pix[$urandom_range(0, 3)][23:0] : bg;
      step($urandom_range(0, 4) != 0, "R5 R6 R3 random");
    end
    step(0, "drain"); step(0, "drain");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule